// File: doc/BRIEF.md
# Cascadable LMS Adaptive Symbol Filter

This block is a 64-tap adaptive FIR filter for a four-level baseband line code. It can serve as an echo canceller or as a decision-feedback equalizer. Each symbol period, a strobe delivers three things: a 2-bit quaternary symbol, a 16-bit signed error sample and a 4-bit step-size shift. One shared multiply-accumulate path then sweeps the taps one per clock. For each tap it reads the coefficient, adds the tap product to an accumulator, applies the LMS correction and writes the coefficient back. The 16-bit signed estimate appears at the end of the same sweep.

The symbols take only four values, so a tap product is a sign change plus an optional times-three (shift and add). No general multiplier is needed. A 64-cycle sweep fits a budget of 75 clocks per symbol.

To build longer filters, several instances are chained. Each stage adds the partial sum from the previous stage on `cas_sum_i`. The symbol that leaves its last tap appears on `cas_sym_o`, to feed the next stage's symbol input.

Top module: `lms_symbol_filter`

## Requirements
- R1: Symbol codes map to levels 00→-3, 01→-1, 10→+1, 11→+3. An accepted strobe shifts `sym_i` into tap 0, so tap k holds the symbol from k strobes ago. The estimate is the sum, over all 64 taps, of the coefficient's high part times the level of the tap's current symbol, plus `cas_sum_i`. It uses the coefficients as they stood before this sweep's update.
- R2: A coefficient is 24-bit signed. Its high part, used in the sum, is bits [23:8] taken as a 16-bit signed value.
- R3: Each sweep updates every coefficient k by adding (err × level) >>> shift, where the shift is arithmetic. The level is that of the symbol held in tap k during the previous sweep; for tap 63 this is the symbol just shifted out. The error is the one sampled with the current strobe.
- R4: The coefficient update saturates at -8388608 and +8388607 and never wraps. A zero error leaves every coefficient unchanged.
- R5: The estimate saturates to the 16-bit range -32768..+32767.
- R6: `est_valid_o` goes high for exactly one cycle, 64 clock edges after the edge that samples the strobe. `est_o` changes only together with that pulse.
- R7: A strobe that arrives while a sweep is in progress is ignored. It does not shift the delay line and does not replace the error or the shift.
- R8: On each accepted strobe, `cas_sym_o` takes the symbol pushed out of tap 63. It holds that value until the next accepted strobe.
- R9: While `rst_ni` is low, all coefficients are cleared to 0, every tap is cleared to code 00, and `est_o`, `est_valid_o` and `cas_sym_o` are cleared to 0.
- R10: The step-size shift `mu_shift_i` is sampled together with the strobe and is used for the whole sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sym_strobe_i | input | 1 | Starts a symbol sweep when idle |
| sym_i | input | 2 | New quaternary symbol code |
| err_i | input | 16 | Signed error sample for the update |
| mu_shift_i | input | 4 | LMS step-size right shift |
| cas_sum_i | input | 16 | Signed partial sum from the previous stage |
| cas_sym_o | output | 2 | Symbol leaving the last tap, for the next stage |
| est_o | output | 16 | Saturated signed estimate |
| est_valid_o | output | 1 | One-cycle pulse when `est_o` is updated |

## Verification
A wrong coefficient, tap symbol or captured error stays inside the block until a later estimate exposes it. A bad product or accumulator step shows in the estimate of the same symbol. A bad update shows one symbol later, because updated coefficients first feed the next sum. A misplaced symbol in the delay line can take up to 64 symbols to reach `cas_sym_o`. Missing saturation shows only after many same-sign updates push a coefficient to its limit, and then as a sudden jump in the estimate while it is pulled back down.

// File: rtl/lms_pkg.sv
package lms_pkg;
  typedef logic [1:0] sym_t;

  // level is negative for codes 00 and 01
  function automatic logic sym_neg(sym_t s);
    return ~s[1];
  endfunction

  // magnitude 3 for codes 00 and 11
  function automatic logic sym_x3(sym_t s);
    return s[1] ~^ s[0];
  endfunction
endpackage

// File: rtl/lms_sym_line.sv
module lms_sym_line
  import lms_pkg::*;
#(
  parameter int N_TAPS = 64
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   shift_i,
  input  sym_t                   sym_i,
  output sym_t [N_TAPS-1:0]      taps_o,
  output sym_t                   last_o
);
  sym_t [N_TAPS-1:0] taps_q;
  sym_t              last_q;

  for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      taps_q[k] <= '0;
      else if (shift_i) taps_q[k] <= (k == 0) ? sym_i : taps_q[(k == 0) ? 0 : k-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      last_q <= '0;
    else if (shift_i) last_q <= taps_q[N_TAPS-1];
  end

  assign taps_o = taps_q;
  assign last_o = last_q;

  // R1
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> taps_o[0] == $past(sym_i));
  // R7
  line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(taps_o) && $stable(last_o));
  // R8
  shift_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> last_o == $past(taps_o[N_TAPS-1]));
endmodule

// File: rtl/lms_coef_bank.sv
module lms_coef_bank #(
  parameter int N_TAPS = 64,
  parameter int COEF_W = 24,
  localparam int AW = $clog2(N_TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [COEF_W-1:0] wdata_i,
  output logic [COEF_W-1:0] rdata_o
);
  logic [COEF_W-1:0] mem_q [N_TAPS];

  for (genvar g = 0; g < N_TAPS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[g] <= '0;
      else if (we_i && addr_i == AW'(g))    mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/lms_tap_mac.sv
module lms_tap_mac
  import lms_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 24,
  parameter int MU_W   = 4,
  localparam int PROD_W = DATA_W + 2
) (
  input  logic [COEF_W-1:0] coef_i,
  input  sym_t              cur_sym_i,
  input  sym_t              prev_sym_i,
  input  logic [DATA_W-1:0] err_i,
  input  logic [MU_W-1:0]   mu_i,
  output logic [PROD_W-1:0] prod_o,
  output logic [COEF_W-1:0] coef_o
);
  localparam logic signed [COEF_W:0] C_MAX = (COEF_W+1)'((64'sd1 <<< (COEF_W-1)) - 1);
  localparam logic signed [COEF_W:0] C_MIN = -C_MAX - (COEF_W+1)'(1);

  function automatic logic signed [PROD_W-1:0] scale(logic signed [DATA_W-1:0] v, sym_t s);
    logic signed [PROD_W-1:0] e, m;
    e = PROD_W'(v);
    m = sym_x3(s) ? (e <<< 1) + e : e;
    return sym_neg(s) ? -m : m;
  endfunction

  logic signed [PROD_W-1:0] inc;
  logic signed [COEF_W:0]   sum;

  always_comb begin
    prod_o = scale($signed(coef_i[COEF_W-1 -: DATA_W]), cur_sym_i);
    inc    = scale($signed(err_i), prev_sym_i) >>> mu_i;
    sum    = (COEF_W+1)'($signed(coef_i)) + (COEF_W+1)'(inc);
    if (sum > C_MAX)      coef_o = C_MAX[COEF_W-1:0];
    else if (sum < C_MIN) coef_o = C_MIN[COEF_W-1:0];
    else                  coef_o = sum[COEF_W-1:0];
  end
endmodule

// File: rtl/lms_symbol_filter.sv
module lms_symbol_filter
  import lms_pkg::*;
#(
  parameter int N_TAPS = 64,
  parameter int DATA_W = 16,
  parameter int COEF_W = 24,
  parameter int MU_W   = 4,
  localparam int IDX_W  = $clog2(N_TAPS),
  localparam int PROD_W = DATA_W + 2,
  localparam int ACC_W  = PROD_W + IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sym_strobe_i,
  input  logic [1:0]        sym_i,
  input  logic [DATA_W-1:0] err_i,
  input  logic [MU_W-1:0]   mu_shift_i,
  input  logic [DATA_W-1:0] cas_sum_i,
  output logic [1:0]        cas_sym_o,
  output logic [DATA_W-1:0] est_o,
  output logic              est_valid_o
);
  localparam logic signed [ACC_W:0] E_MAX = (ACC_W+1)'((64'sd1 <<< (DATA_W-1)) - 1);
  localparam logic signed [ACC_W:0] E_MIN = -E_MAX - (ACC_W+1)'(1);

  logic                     busy_q, vld_q;
  logic [IDX_W-1:0]         idx_q;
  logic signed [ACC_W-1:0]  acc_q, acc_nxt;
  logic [DATA_W-1:0]        err_q, est_q;
  logic [MU_W-1:0]          mu_q;
  logic                     accept, last_tap;
  logic signed [ACC_W:0]    total;

  sym_t [N_TAPS-1:0] taps, prev_line;
  sym_t              line_last;
  logic [COEF_W-1:0] coef_rd, coef_wr;
  logic [PROD_W-1:0] prod;

  assign accept   = sym_strobe_i && !busy_q;
  assign last_tap = idx_q == IDX_W'(N_TAPS-1);

  lms_sym_line #(.N_TAPS(N_TAPS)) u_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (accept),
    .sym_i   (sym_i),
    .taps_o  (taps),
    .last_o  (line_last)
  );

  // symbols as they sat one sweep earlier
  for (genvar k = 0; k < N_TAPS; k++) begin : g_prev
    if (k == N_TAPS-1) begin : g_end
      assign prev_line[k] = line_last;
    end else begin : g_mid
      assign prev_line[k] = taps[k+1];
    end
  end

  lms_coef_bank #(.N_TAPS(N_TAPS), .COEF_W(COEF_W)) u_coef (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (busy_q),
    .addr_i  (idx_q),
    .wdata_i (coef_wr),
    .rdata_o (coef_rd)
  );

  lms_tap_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .MU_W(MU_W)) u_mac (
    .coef_i     (coef_rd),
    .cur_sym_i  (taps[idx_q]),
    .prev_sym_i (prev_line[idx_q]),
    .err_i      (err_q),
    .mu_i       (mu_q),
    .prod_o     (prod),
    .coef_o     (coef_wr)
  );

  always_comb begin
    acc_nxt = acc_q + ACC_W'($signed(prod));
    total   = (ACC_W+1)'(acc_nxt) + (ACC_W+1)'($signed(cas_sum_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      idx_q  <= '0;
      acc_q  <= '0;
      err_q  <= '0;
      mu_q   <= '0;
      est_q  <= '0;
    end else begin
      vld_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        acc_q  <= '0;
        err_q  <= err_i;
        mu_q   <= mu_shift_i;
      end else if (busy_q) begin
        idx_q <= idx_q + IDX_W'(1);
        acc_q <= acc_nxt;
        if (last_tap) begin
          busy_q <= 1'b0;
          vld_q  <= 1'b1;
          if (total > E_MAX)      est_q <= E_MAX[DATA_W-1:0];
          else if (total < E_MIN) est_q <= E_MIN[DATA_W-1:0];
          else                    est_q <= total[DATA_W-1:0];
        end
      end
    end
  end

  assign est_o       = est_q;
  assign est_valid_o = vld_q;
  assign cas_sym_o   = line_last;

  // R6
  est_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    est_valid_o |=> !est_valid_o);
  // R6
  est_after_sweep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    est_valid_o |-> $past(busy_q && last_tap));
  // R6
  est_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !est_valid_o |-> $stable(est_o));
  // R6
  sweep_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !last_tap |=> busy_q && idx_q == $past(idx_q) + IDX_W'(1));
  // R4
  zero_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && err_q == '0 |-> coef_wr == coef_rd);
  // R7
  busy_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(err_q) && $stable(mu_q));
endmodule

// File: tb/lms_symbol_filter_tb_top.sv
`timescale 1ns/1ps
module lms_symbol_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        strobe = 1'b0;
  logic [1:0]  sym = '0;
  logic [15:0] err = '0;
  logic [3:0]  mu = '0;
  logic [15:0] cas = '0;
  logic [1:0]  cas_sym;
  logic [15:0] est;
  logic        est_vld;

  int n_chk = 0;
  int n_fail = 0;

  int          coef_m [64];
  logic [1:0]  dl_m   [64];
  logic [1:0]  out_m;

  always #2.5 clk = ~clk;

  lms_symbol_filter dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .sym_strobe_i (strobe),
    .sym_i        (sym),
    .err_i        (err),
    .mu_shift_i   (mu),
    .cas_sum_i    (cas),
    .cas_sym_o    (cas_sym),
    .est_o        (est),
    .est_valid_o  (est_vld)
  );

  // {sym, err, mu, cas}
  localparam logic [37:0] VEC [16] = '{
    {2'b11, 16'h0400, 4'd2, 16'h0000},
    {2'b00, 16'h0800, 4'd3, 16'h0010},
    {2'b10, 16'hF800, 4'd1, 16'hFFF0},
    {2'b01, 16'h1234, 4'd4, 16'h0100},
    {2'b11, 16'h7FFF, 4'd0, 16'h0000},
    {2'b11, 16'h8001, 4'd5, 16'h0200},
    {2'b00, 16'h4000, 4'd2, 16'hFE00},
    {2'b10, 16'h0001, 4'd0, 16'h0000},
    {2'b01, 16'hC000, 4'd3, 16'h7000},
    {2'b11, 16'h2000, 4'd1, 16'h8000},
    {2'b00, 16'h0000, 4'd0, 16'h0001},
    {2'b10, 16'h3FFF, 4'd6, 16'h0000},
    {2'b01, 16'hA000, 4'd2, 16'h1000},
    {2'b11, 16'h0F00, 4'd7, 16'hF000},
    {2'b00, 16'hE000, 4'd1, 16'h0000},
    {2'b10, 16'h5555, 4'd15, 16'h0033}
  };

  function automatic int lvl(logic [1:0] c);
    case (c)
      2'b00:   return -3;
      2'b01:   return -1;
      2'b10:   return 1;
      default: return 3;
    endcase
  endfunction

  function automatic int sat(int v, int lo, int hi);
    return (v > hi) ? hi : (v < lo) ? lo : v;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 64; k++) begin
      coef_m[k] = 0;
      dl_m[k] = 2'b00;
    end
    out_m = 2'b00;
  endtask

  // returns expected estimate; advances the reference state
  function automatic int model_step(logic [1:0] s, logic [15:0] e, logic [3:0] m, logic [15:0] c);
    logic [1:0] old [64];
    int acc;
    for (int k = 0; k < 64; k++) old[k] = dl_m[k];
    out_m = dl_m[63];
    for (int k = 63; k > 0; k--) dl_m[k] = dl_m[k-1];
    dl_m[0] = s;
    acc = int'($signed(c));
    for (int k = 0; k < 64; k++) acc += (coef_m[k] >>> 8) * lvl(dl_m[k]);
    for (int k = 0; k < 64; k++)
      coef_m[k] = sat(coef_m[k] + ((int'($signed(e)) * lvl(old[k])) >>> m), -8388608, 8388607);
    return sat(acc, -32768, 32767);
  endfunction

  task automatic do_sym(logic [1:0] s, logic [15:0] e, logic [3:0] m, logic [15:0] c,
                        string req, bit inject);
    int exp_est, n;
    @(negedge clk);
    sym = s; err = e; mu = m; cas = c; strobe = 1'b1;
    exp_est = model_step(s, e, m, c);
    @(negedge clk);
    strobe = 1'b0;
    n = 1;
    while (!est_vld && n < 100) begin
      @(negedge clk);
      n++;
      if (inject && n == 30) begin
        strobe = 1'b1; sym = ~s; err = 16'h7FFF; mu = 4'd0;
      end else if (inject && n == 31) begin
        strobe = 1'b0;
      end
    end
    check("R6 latency", n, 65);
    check(req, int'($signed(est)), exp_est);
    check("R8 cascade symbol", int'(cas_sym), int'(out_m));
    @(negedge clk);
    check("R6 pulse width", int'(est_vld), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R6: watchdog expired, actual hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 est", int'(est), 0);
    check("R9 valid", int'(est_vld), 0);
    check("R9 cascade symbol", int'(cas_sym), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R10 vector walk
    for (int i = 0; i < 16; i++)
      do_sym(VEC[i][37:36], VEC[i][35:20], VEC[i][19:16], VEC[i][15:0], "R1 R2 R3 R10 table", 1'b0);

    // R7 strobe during a sweep is ignored
    do_sym(2'b10, 16'h0300, 4'd2, 16'h0000, "R7 busy strobe", 1'b1);
    do_sym(2'b01, 16'h0100, 4'd1, 16'h0000, "R7 after busy strobe", 1'b0);

    // R4 zero error leaves coefficients unchanged
    do_sym(2'b11, 16'h0000, 4'd0, 16'h0000, "R4 zero error", 1'b0);
    do_sym(2'b11, 16'h0000, 4'd0, 16'h0000, "R4 zero error repeat", 1'b0);

    // R4 R5 drive coefficients to the positive limit, then pull back through negative
    for (int i = 0; i < 160; i++)
      do_sym(2'b11, 16'h7FFF, 4'd0, 16'h0000, "R4 R5 positive saturation", 1'b0);
    for (int i = 0; i < 200; i++)
      do_sym(2'b11, 16'h8001, 4'd0, 16'h0000, "R4 R5 negative sweep", 1'b0);
    for (int i = 0; i < 8; i++)
      do_sym(2'(i), 16'h0000, 4'd0, 16'h8000, "R5 mixed symbols at limit", 1'b0);

    // R9 reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    check("R9 est after reset", int'(est), 0);
    check("R9 cascade after reset", int'(cas_sym), 0);
    rst_ni = 1'b1;
    do_sym(2'b11, 16'h0000, 4'd0, 16'h1234, "R9 cleared coefficients", 1'b0);
    do_sym(2'b10, 16'h0000, 4'd0, 16'h0000, "R9 cleared coefficients second", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule